// File: doc/BRIEF.md
# Radix-2 FFT Butterfly Index Sequencer

This block produces the complete in-place butterfly schedule of a radix-2 transform over N points, where N is two raised to the parameter `LOG2N`. Each accepted step delivers three indices: the lower element of a butterfly, the upper element, and the position in the twiddle table. A processing unit downstream consumes them. The block drives addresses only. It does not reorder the input into bit-reversed order, it holds no data, and it does no arithmetic.

A single-cycle start request issued while the block is idle launches one transform. The sequence runs through three nested loops. The outer loop is the stage, whose butterfly span starts at 2 and doubles each stage up to N. The middle loop is the group within the stage. The inner loop is the pair within the group. Each stage steps the twiddle index by a stride of N divided by the span. Each transform emits (N/2)·log2(N) triples. A valid/ready handshake lets the consumer hold any triple for as long as it needs. A one-cycle done pulse marks the acceptance of the last triple, and the block then returns to idle.

Top module: `fft_bfly_seq`

## Requirements
- R1: While reset is held and right after it, `outValid` and `doneFlag` are 0.
- R2: A start pulse seen while idle makes `outValid` 1 in the next cycle, with the triple lo=0, hi=1, tw=0.
- R3: Triples come out stage by stage with spans 2, 4, …, N. Within a stage they come group by group, with group bases 0, span, 2·span, and so on below N. Within a group they come pair by pair, and lo runs from the base up to base+span/2−1.
- R4: For every triple, hi = lo + span/2. The difference hi−lo is therefore a power of two.
- R5: The twiddle index is 0 for the first pair of each group. It grows by N/span for each further pair, so it always stays below N/2.
- R6: One transform emits exactly (N/2)·log2(N) accepted triples. For N=16 that is 32.
- R7: While `outValid` is 1 and `outReady` is 0, the triple and `outValid` stay unchanged in the next cycle.
- R8: `doneFlag` is 1 only in the cycle in which the final triple is accepted (`outValid` and `outReady` both 1). In the cycle after that, `outValid` is 0.
- R9: A start pulse while `outValid` is 1 is ignored. This includes the cycle of the final acceptance. The sequence neither restarts nor grows.
- R10: While idle and without a start pulse, `outValid` stays 0 whatever `outReady` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Request to begin a transform; acted on only when idle |
| outReady | input | 1 | Consumer accepts the current triple |
| outValid | output | 1 | A triple is presented |
| loIdx | output | LOG2N | Lower element index |
| hiIdx | output | LOG2N | Upper element index |
| twIdx | output | LOG2N | Twiddle table index |
| doneFlag | output | 1 | Final triple accepted this cycle |

## Verification
Two functions can fall in the same cycle: acceptance of the final triple, which raises the done pulse, and a fresh start request. The bench holds the start input high on every cycle of a run, including the done cycle, while the ready input stalls in several patterns. It then judges that the cycle after done shows no valid output and that no more than the expected 32 triples appeared. Each accepted triple is compared with a schedule computed in the bench from nested loops. Each stalled cycle is compared with the triple seen in the cycle before it.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  typedef struct packed {
    logic load;   // restart all loop counters at the first triple
    logic step;   // move to the next triple
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;
endpackage

// File: rtl/fft_seq_ctrl.sv
module fft_seq_ctrl
  import fft_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       outReady,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       running,
  output logic       finishNow
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    finishNow   = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          stateNext   = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (outReady) begin
          if (lastStep) begin
            finishNow = 1'b1;
            stateNext = SEQ_IDLE;
          end else begin
            strobe.step = 1'b1;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign running = (state == SEQ_RUN);
endmodule

// File: rtl/fft_seq_dp.sv
module fft_seq_dp
  import fft_seq_pkg::*;
#(
  parameter int LOG2N = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  output logic [LOG2N-1:0] loIdx,
  output logic [LOG2N-1:0] hiIdx,
  output logic [LOG2N-1:0] twIdx,
  output logic             lastStep
);
  localparam int N     = 1 << LOG2N;
  localparam int IDXW  = LOG2N;
  localparam int STW   = (LOG2N > 1) ? $clog2(LOG2N) : 1;
  localparam logic [IDXW-1:0] HALFN  = IDXW'(N / 2);
  localparam logic [IDXW:0]   NFULL  = (IDXW+1)'(N);
  localparam logic [STW-1:0]  SHLAST = STW'(LOG2N - 1);

  logic [STW-1:0]  stageSh;    // log2 of half-span
  logic [IDXW-1:0] groupBase;
  logic [IDXW-1:0] pairOff;
  logic [IDXW-1:0] twReg;

  logic [IDXW-1:0] halfSize, stride;
  logic [IDXW:0]   nextBase;
  logic            pairLast, groupLast, stageLast;

  always_comb begin
    halfSize  = IDXW'(1) << stageSh;
    stride    = HALFN >> stageSh;
    nextBase  = {1'b0, groupBase} + ({1'b0, halfSize} << 1);
    pairLast  = (pairOff == halfSize - IDXW'(1));
    groupLast = (nextBase == NFULL);
    stageLast = (stageSh == SHLAST);
    lastStep  = pairLast && groupLast && stageLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageSh   <= '0;
      groupBase <= '0;
      pairOff   <= '0;
      twReg     <= '0;
    end else if (strobe.load) begin
      stageSh   <= '0;
      groupBase <= '0;
      pairOff   <= '0;
      twReg     <= '0;
    end else if (strobe.step) begin
      if (!pairLast) begin
        pairOff <= pairOff + IDXW'(1);
        twReg   <= twReg + stride;
      end else begin
        pairOff <= '0;
        twReg   <= '0;
        if (!groupLast) begin
          groupBase <= nextBase[IDXW-1:0];
        end else begin
          groupBase <= '0;
          stageSh   <= stageSh + STW'(1);
        end
      end
    end
  end

  assign loIdx = groupBase + pairOff;
  assign hiIdx = loIdx + halfSize;
  assign twIdx = twReg;
endmodule

// File: rtl/fft_bfly_seq.sv
module fft_bfly_seq
  import fft_seq_pkg::*;
#(
  parameter int LOG2N = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             outReady,
  output logic             outValid,
  output logic [LOG2N-1:0] loIdx,
  output logic [LOG2N-1:0] hiIdx,
  output logic [LOG2N-1:0] twIdx,
  output logic             doneFlag
);
  seqStrobe_t strobe;
  logic       lastStep;

  fft_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .outReady   (outReady),
    .lastStep   (lastStep),
    .strobe     (strobe),
    .running    (outValid),
    .finishNow  (doneFlag)
  );

  fft_seq_dp #(.LOG2N(LOG2N)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loIdx    (loIdx),
    .hiIdx    (hiIdx),
    .twIdx    (twIdx),
    .lastStep (lastStep)
  );
endmodule

// File: rtl/fft_bfly_seq_chk.sv
module fft_bfly_seq_chk #(
  parameter int LOG2N = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             outReady,
  input logic             outValid,
  input logic [LOG2N-1:0] loIdx,
  input logic [LOG2N-1:0] hiIdx,
  input logic [LOG2N-1:0] twIdx,
  input logic             doneFlag
);
  localparam logic [LOG2N-1:0] HALFN = LOG2N'((1 << LOG2N) / 2);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |-> !outValid && !doneFlag);

  assert_start_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && startPulse |=> outValid && loIdx == '0 && hiIdx == LOG2N'(1) && twIdx == '0);

  assert_span_pow2_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (hiIdx > loIdx) && $countones(hiIdx - loIdx) == 1);

  assert_twiddle_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> twIdx < HALFN);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(loIdx) && $stable(hiIdx) && $stable(twIdx));

  assert_done_handshake_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> outValid && outReady);

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |=> !outValid && !doneFlag);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && startPulse && !doneFlag |=> outValid);

  assert_idle_stays_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && !startPulse |=> !outValid);
endmodule

bind fft_bfly_seq fft_bfly_seq_chk #(.LOG2N(LOG2N)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .outReady   (outReady),
  .outValid   (outValid),
  .loIdx      (loIdx),
  .hiIdx      (hiIdx),
  .twIdx      (twIdx),
  .doneFlag   (doneFlag)
);

// File: tb/fft_bfly_seq_tb_top.sv
`timescale 1ns/1ps
module fft_bfly_seq_tb_top;
  localparam int LOG2N = 4;
  localparam int N     = 1 << LOG2N;
  localparam int TOTAL = (N / 2) * LOG2N;

  logic clk = 1'b0;
  logic rstN, startPulse, outReady, outValid, doneFlag;
  logic [LOG2N-1:0] loIdx, hiIdx, twIdx;
  int checks = 0, failures = 0;
  int expLo[TOTAL], expHi[TOTAL], expTw[TOTAL];

  always #2 clk = ~clk;

  fft_bfly_seq #(.LOG2N(LOG2N)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .outReady(outReady),
    .outValid(outValid), .loIdx(loIdx), .hiIdx(hiIdx), .twIdx(twIdx),
    .doneFlag(doneFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit readyAt(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) != 1;
      2: return (cyc % 2) == 1;
      default: return (cyc % 5) >= 2;
    endcase
  endfunction

  task automatic runOne(input int mode, input bit spam);
    int k = 0, cyc = 0;
    int hLo = 0, hHi = 0, hTw = 0;
    bit held = 0;
    @(negedge clk); startPulse = 1'b1; outReady = 1'b0;
    while (k < TOTAL && cyc < 4000) begin
      @(negedge clk);
      startPulse = spam;
      outReady   = readyAt(mode, cyc);
      #1;
      if (cyc == 0)
        chk(outValid && loIdx == 0 && hiIdx == 1 && twIdx == 0, "R2 first triple", int'(loIdx), 0);
      chk(outValid == 1'b1, "R9 valid during run", int'(outValid), 1);
      if (held) begin
        chk(int'(loIdx) == hLo && int'(hiIdx) == hHi && int'(twIdx) == hTw,
            "R7 stall hold", int'(loIdx), hLo);
        held = 0;
      end
      if (outValid && outReady) begin
        chk(int'(loIdx) == expLo[k], "R3 lower index", int'(loIdx), expLo[k]);
        chk(int'(hiIdx) == expHi[k], "R4 upper index", int'(hiIdx), expHi[k]);
        chk(int'(twIdx) == expTw[k], "R5 twiddle index", int'(twIdx), expTw[k]);
        chk(doneFlag == (k == TOTAL - 1), "R8 done position", int'(doneFlag), int'(k == TOTAL - 1));
        k++;
      end else if (outValid) begin
        chk(doneFlag == 1'b0, "R8 no done while stalled", int'(doneFlag), 0);
        hLo = int'(loIdx); hHi = int'(hiIdx); hTw = int'(twIdx);
        held = 1;
      end
      cyc++;
    end
    chk(k == TOTAL, "R6 triple count", k, TOTAL);
    @(negedge clk); startPulse = 1'b0; outReady = 1'b1; #1;
    chk(!outValid && !doneFlag, "R8 idle after done", int'(outValid), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); outReady = (i % 2) == 0; #1;
      chk(!outValid, "R10 idle without start", int'(outValid), 0);
    end
  endtask

  initial begin
    int k = 0;
    for (int size = 2; size <= N; size *= 2)
      for (int g = 0; g < N; g += size)
        for (int j = g; j < g + size / 2; j++) begin
          expLo[k] = j;
          expHi[k] = j + size / 2;
          expTw[k] = (j - g) * (N / size);
          k++;
        end

    rstN = 1'b0; startPulse = 1'b0; outReady = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(!outValid && !doneFlag, "R1 reset state", int'(outValid), 0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); outReady = (i % 2) == 1; #1;
      chk(!outValid, "R10 idle after reset", int'(outValid), 0);
    end

    runOne(0, 1'b0);
    runOne(1, 1'b0);
    runOne(2, 1'b1);
    runOne(3, 1'b1);
    runOne(0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule